// File: doc/BRIEF.md
# Quadrant-Locked Bit-Clock Recovery

This block recovers a bit-sampling strobe from a serial line that carries level-coded data, for example a low-speed USB stream at 1.5 Mbit/s, using only the system clock. A 32-bit phase accumulator grows by a programmable frequency word on every clock. The nominal word is round(2^32 x bit rate / clock rate), which is 80530637 for 1.5 Mbit/s from 80 MHz, or about 53.33 clocks per bit. The two top accumulator bits divide each bit period into four quadrants. Quadrant 1 is where data is sampled, quadrant 3 is where line transitions are expected, and quadrants 0 and 2 are guard bands.

Each time the synchronized line changes level, the block looks at the quadrant the accumulator is in. It adds a single extra phase step, sized by that quadrant, so that later transitions fall into quadrant 3. A transition in quadrant 1 should not occur in a valid stream. It raises a sticky error flag and shifts the phase by half a period. The block outputs a one-clock sample enable at the start of quadrant 1. It also outputs the accumulator MSB, which can serve as a scope trigger. Line decoding, unstuffing and CRC are handled downstream.

Top module: `qlock_bitclk`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to zero, clears the error flag and the synchronizer, and loads the default frequency word. While reset is held, `phase_msb`, `sample_en` and `err_flag` are 0.
- R2: With no line transition in effect, the accumulator advances by exactly the current frequency word, modulo 2^32, on every clock.
- R3: `phase_msb` always equals bit 31 of the accumulator.
- R4: A transition acted on while the quadrant (accumulator bits [31:30]) is 3 adds no extra step.
- R5: A transition acted on in quadrant 2 adds an extra 2^30 once, on top of the frequency word.
- R6: A transition acted on in quadrant 0 adds an extra 3 x 2^30 once, on top of the frequency word.
- R7: A transition acted on in quadrant 1 adds an extra 2^31 once and sets `err_flag` on the following clock.
- R8: `line_in` passes through a two-flop synchronizer. A change presented before clock edge k is acted on at edge k+2, using the quadrant held just before that edge.
- R9: `sample_en` is high for exactly the one clock in which the quadrant has just changed from 0 to 1.
- R10: `err_flag` stays set until `err_clr` is high at a clock edge. If a quadrant-1 transition happens at the same edge, the set wins.
- R11: A word on `freq_word` with `freq_load` high at edge k becomes the increment used from edge k+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous serial line level |
| freq_word | input | 32 | Frequency word to load |
| freq_load | input | 1 | Loads `freq_word` as the new increment |
| err_clr | input | 1 | Clears the sticky error flag |
| sample_en | output | 1 | One-clock strobe at the start of quadrant 1 |
| phase_msb | output | 1 | Accumulator bit 31 |
| err_flag | output | 1 | Sticky flag for a transition seen in quadrant 1 |

## Verification
A single line transition is placed at every clock offset across two bit periods, using a coarse frequency word of 16 clocks per bit. Each of the four quadrant corrections is therefore hit at every position within its quadrant. A mis-sized step appears as a shifted `phase_msb` and `sample_en` pattern that is attributed to the quadrant where it occurred. A second sweep uses an 8-clock bit, which tells the synchronizer latency apart from the quadrant width. A free-running count of accumulator wraps with the default word checks the rate. Scenarios that load a new word and that clear the error flag while it is set check the load timing and the sticky behaviour.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned PHASE_W = 32;
    localparam int unsigned QUAD_W  = 2;

    typedef enum logic [QUAD_W-1:0] {
        QD_LEAD   = 2'd0,
        QD_SAMPLE = 2'd1,
        QD_LATE   = 2'd2,
        QD_EDGE   = 2'd3
    } quad_e;

    typedef struct packed {
        logic  seen;
        quad_e quad;
    } edge_evt_t;

    // Extra phase step for a transition: (3 - quadrant) quarter periods.
    function automatic logic [PHASE_W-1:0] quad_step(input quad_e q);
        logic [QUAD_W-1:0] quarters;
        quarters = 2'd3 - q;
        return {quarters, {(PHASE_W-QUAD_W){1'b0}}};
    endfunction
endpackage

// File: rtl/nco_line_sync.sv
module nco_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic edge_seen
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], line_in};
        end
    end

    assign edge_seen = chain_q[DEPTH-1] ^ chain_q[DEPTH-2];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter logic [PHASE_W-1:0] DEF_FREQ = 32'd80530637
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic               freq_load,
    input  edge_evt_t          evt,
    output logic [PHASE_W-1:0] phase,
    output logic [PHASE_W-1:0] incr
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] incr_q;
    logic [PHASE_W-1:0] corr;

    always_comb begin
        corr = '0;
        if (evt.seen) begin
            corr = quad_step(evt.quad);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            incr_q  <= DEF_FREQ;
        end else begin
            phase_q <= phase_q + incr_q + corr;
            if (freq_load) begin
                incr_q <= freq_word;
            end
        end
    end

    assign phase = phase_q;
    assign incr  = incr_q;
endmodule

// File: rtl/nco_quad_track.sv
module nco_quad_track
    import nco_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_evt_t evt,
    input  logic      err_clr,
    output logic      sample_en,
    output logic      err_flag
);
    quad_e prev_q;
    logic  err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= QD_LEAD;
            err_q  <= 1'b0;
        end else begin
            prev_q <= evt.quad;
            if (evt.seen && evt.quad == QD_SAMPLE) begin
                err_q <= 1'b1;
            end else if (err_clr) begin
                err_q <= 1'b0;
            end
        end
    end

    assign sample_en = (prev_q == QD_LEAD) && (evt.quad == QD_SAMPLE);
    assign err_flag  = err_q;
endmodule

// File: rtl/qlock_bitclk.sv
module qlock_bitclk
    import nco_pkg::*;
#(
    parameter logic [PHASE_W-1:0] DEF_FREQ    = 32'd80530637,
    parameter int unsigned        SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_in,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic               freq_load,
    input  logic               err_clr,
    output logic               sample_en,
    output logic               phase_msb,
    output logic               err_flag
);
    logic               edge_seen;
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] incr_q;
    edge_evt_t          evt;

    nco_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .edge_seen (edge_seen)
    );

    assign evt.seen = edge_seen;
    assign evt.quad = quad_e'(phase[PHASE_W-1 -: QUAD_W]);

    nco_phase_acc #(.DEF_FREQ(DEF_FREQ)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .freq_word (freq_word),
        .freq_load (freq_load),
        .evt       (evt),
        .phase     (phase),
        .incr      (incr_q)
    );

    nco_quad_track u_track (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .err_clr   (err_clr),
        .sample_en (sample_en),
        .err_flag  (err_flag)
    );

    assign phase_msb = phase[PHASE_W-1];
endmodule

// File: rtl/qlock_bitclk_chk.sv
module qlock_bitclk_chk
    import nco_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               edge_seen,
    input logic [PHASE_W-1:0] phase,
    input logic [PHASE_W-1:0] incr_q,
    input logic               err_clr,
    input logic               sample_en,
    input logic               err_flag
);
    localparam logic [PHASE_W-1:0] QTR1 = {2'd1, {(PHASE_W-2){1'b0}}};
    localparam logic [PHASE_W-1:0] QTR2 = {2'd2, {(PHASE_W-2){1'b0}}};
    localparam logic [PHASE_W-1:0] QTR3 = {2'd3, {(PHASE_W-2){1'b0}}};

    logic [QUAD_W-1:0] quad;
    assign quad = phase[PHASE_W-1 -: QUAD_W];

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (phase == '0 && !err_flag && !sample_en)); // R1

    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        !edge_seen |=> phase == $past(phase) + $past(incr_q)); // R2

    AST_EDGE_Q3_HOLD: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && quad == 2'd3) |=> phase == $past(phase) + $past(incr_q)); // R4

    AST_EDGE_Q2_ADV: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && quad == 2'd2) |=> phase == $past(phase) + $past(incr_q) + QTR1); // R5

    AST_EDGE_Q0_RET: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && quad == 2'd0) |=> phase == $past(phase) + $past(incr_q) + QTR3); // R6

    AST_EDGE_Q1_ERR: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && quad == 2'd1) |=> (err_flag && phase == $past(phase) + $past(incr_q) + QTR2)); // R7

    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> !sample_en); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag); // R10
endmodule

bind qlock_bitclk qlock_bitclk_chk i_qlock_bitclk_chk (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (edge_seen),
    .phase     (phase),
    .incr_q    (incr_q),
    .err_clr   (err_clr),
    .sample_en (sample_en),
    .err_flag  (err_flag)
);

// File: tb/test_qlock_bitclk.sv
module test_qlock_bitclk;
    localparam logic [31:0] DEF_W = 32'd80530637;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_in = 1'b0;
    logic [31:0] freq_word = '0;
    logic        freq_load = 1'b0;
    logic        err_clr = 1'b0;
    logic        sample_en, phase_msb, err_flag;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    qlock_bitclk i_qlock_bitclk (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .freq_word (freq_word),
        .freq_load (freq_load),
        .err_clr   (err_clr),
        .sample_en (sample_en),
        .phase_msb (phase_msb),
        .err_flag  (err_flag)
    );

    // Reference model built from the requirements.
    logic [31:0] m_acc, m_inc;
    logic        m_s1, m_s2, m_s3, m_err;
    logic [1:0]  m_qprev;
    string       cur_tag = "R2";

    always @(posedge clk) begin
        logic        e;
        logic [1:0]  q;
        logic [31:0] extra;
        if (rst) begin
            m_acc = '0; m_inc = DEF_W; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_err = 0; m_qprev = 2'd0; cur_tag = "R2";
        end else begin
            e = m_s2 ^ m_s3;
            q = m_acc[31:30];
            extra = '0;
            if (e) begin
                case (q)
                    2'd3: begin extra = 32'h0000_0000; cur_tag = "R8 R4"; end
                    2'd2: begin extra = 32'h4000_0000; cur_tag = "R8 R5"; end
                    2'd0: begin extra = 32'hC000_0000; cur_tag = "R8 R6"; end
                    default: begin extra = 32'h8000_0000; cur_tag = "R8 R7"; end
                endcase
            end
            if (e && q == 2'd1) m_err = 1'b1;
            else if (err_clr)   m_err = 1'b0;
            m_qprev = q;
            m_acc = m_acc + m_inc + extra;
            if (freq_load) begin
                m_inc = freq_word;
                cur_tag = "R11";
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = line_in;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: wait for the falling edge, compare outputs with the model.
    task automatic tick();
        @(negedge clk);
        check({cur_tag, " R3"}, phase_msb, m_acc[31], "phase_msb");
        check("R9", sample_en, (m_qprev == 2'd0) && (m_acc[31:30] == 2'd1), "sample_en");
        check("R7 R10", err_flag, m_err, "err_flag");
    endtask

    task automatic run_case(input int off, input logic [31:0] w, input bit clr_early);
        rst = 1'b1;
        tick();
        check("R1", phase_msb, 1'b0, "reset phase_msb");
        check("R1", sample_en, 1'b0, "reset sample_en");
        check("R1", err_flag, 1'b0, "reset err_flag");
        rst = 1'b0;
        freq_word = w; freq_load = 1'b1;
        tick();
        freq_load = 1'b0;
        for (int i = 0; i < 24 + off; i++) tick();
        line_in = ~line_in;
        for (int i = 0; i < 12; i++) tick();
        if (clr_early) begin
            err_clr = 1'b1; tick(); err_clr = 1'b0;
        end
        line_in = ~line_in;
        for (int i = 0; i < 30; i++) tick();
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        longint unsigned wraps_exp;
        int              wraps;
        logic            prev_msb;
        tick(); tick();
        check("R1", err_flag, 1'b0, "reset err_flag");
        check("R1", phase_msb, 1'b0, "reset phase_msb");
        // R2: default rate, count MSB falls over 2000 clocks.
        rst = 1'b0;
        wraps = 0; prev_msb = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            tick();
            if (prev_msb && !phase_msb) wraps++;
            prev_msb = phase_msb;
        end
        wraps_exp = (longint'(2000) * longint'(DEF_W)) >> 32;
        total++;
        if (longint'(wraps) != longint'(wraps_exp)) begin
            bad++;
            $display("FAIL R2 wrap count: actual=%0d expected=%0d", wraps, wraps_exp);
        end
        // Sweep transition placement across two bit periods.
        for (int o = 0; o < 32; o++) run_case(o, 32'h1000_0000, (o % 4) == 0);
        for (int o = 0; o < 16; o++) run_case(o, 32'h2000_0000, (o % 3) == 0);
        // R11: reload mid-stream with another word.
        rst = 1'b0;
        freq_word = 32'h0C00_0000; freq_load = 1'b1; tick(); freq_load = 1'b0;
        for (int i = 0; i < 40; i++) tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule